// File: doc/BRIEF.md
# Scalar Condition-Code ALU

This block is a single-stage scalar integer execution unit. Each accepted operation produces a same-width result and, when asked to, a fresh four-bit condition record. The record holds carry (unsigned overflow), signed overflow, negative and zero. It supports addition, subtraction, a variable logical left shift, and an unsigned widening multiply that returns a high and a low half. A shift reports the bits it pushes out of the word as overflow, so software can detect a lost value without extra instructions.

One operation is presented per cycle with `in_valid`. Results and flags are registered and appear one cycle later, together with `out_valid`. A two-state sequencer tracks the output valid. In `ST_IDLE` no result is pending. A valid input moves it to `ST_DONE` (transition *issue*). It stays in `ST_DONE` while valid inputs keep arriving (*stream*), and returns to `ST_IDLE` on a cycle without input (*drain*). With no input in `ST_IDLE` it stays there (*rest*). The condition record is always rewritten as one unit. It is never merged with older flags.

Top module: `scalar_cc_alu`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a cycle where `in_valid` was high, and low otherwise.
- R2: Opcode 2'b00 adds: `res_lo` = (a+b) mod 2^W. C is the carry out of the W-bit sum. V is set when the true signed sum does not fit in W signed bits.
- R3: Opcode 2'b01 subtracts: `res_lo` = (a-b) mod 2^W. C is set when a < b unsigned (borrow). V is set when the true signed difference does not fit in W signed bits.
- R4: Opcode 2'b10 shifts left: `res_lo` = (a << shamt) mod 2^W. C is the OR of every bit shifted out above bit W-1.
- R5: For opcode 2'b10, V is set when a, read as signed and multiplied by 2^shamt, does not fit in W signed bits.
- R6: Opcode 2'b11 multiplies unsigned: {`res_hi`,`res_lo`} = a*b. C is set when `res_hi` is nonzero, and V is 0.
- R7: For opcodes other than 2'b11, `res_hi` is 0.
- R8: When flags are written, N equals bit W-1 of `res_lo` and Z is set when `res_lo` is zero.
- R9: Flags are written only in the cycle after `in_valid` and `set_flags` were both high, and then all four together. Otherwise they keep their value, even when the results change.
- R10: Results keep their value in the cycle after a cycle without `in_valid`.
- R11: After reset, `out_valid`, both results and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 2 | 00 add, 01 subtract, 10 shift left, 11 multiply |
| set_flags | input | 1 | Write the condition record for this operation |
| opa | input | W | First operand |
| opb | input | W | Second operand |
| shamt | input | log2(W) | Left shift amount |
| out_valid | output | 1 | Registered result is new this cycle |
| res_lo | output | W | Result, or low half of the product |
| res_hi | output | W | High half of the product, zero otherwise |
| flag_c | output | 1 | Carry / unsigned overflow / borrow |
| flag_v | output | 1 | Signed overflow |
| flag_n | output | 1 | Negative |
| flag_z | output | 1 | Zero |

## Verification
Two situations are hard to reach from the ports. The first is a left shift that overflows in the signed sense but pushes out only zero bits, or the reverse. The second is an operation that changes the result while the flags must stay exactly as an earlier operation left them. Directed cases build both: a shift of 0x40000000 by one, a shift of all-ones by four, and a run of flagged operations followed by unflagged ones. Seeded random traffic then mixes random opcodes, edge-value operands, random `set_flags` and idle gaps. The bench carries its own flag register, so a held record is compared over many later results.

// File: rtl/scalar_cc_alu_pkg.sv
package scalar_cc_alu_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_SHL = 2'b10,
        OP_MUL = 2'b11
    } alu_op_e;

    typedef struct packed {
        logic c;
        logic v;
        logic n;
        logic z;
    } cc_rec_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } seq_state_e;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W = 32
) (
    input  logic         sub,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum,
    output logic         carry,
    output logic         ovf
);
    logic [W:0]   wide;
    logic [W-1:0] b_eff;

    assign b_eff = sub ? ~b : b;
    assign wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
    assign sum   = wide[W-1:0];

    // borrow for subtract is the inverse of the adder carry
    assign carry = sub ? ~wide[W] : wide[W];

    // signed overflow: effective operand signs agree, result sign differs
    assign ovf = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
endmodule

// File: rtl/alu_shl.sv
module alu_shl #(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0]  a,
    input  logic [SW-1:0] amt,
    output logic [W-1:0]  res,
    output logic          lost,
    output logic          sovf
);
    logic [2*W-1:0] zext;
    logic [2*W-1:0] sext;
    logic [W:0]     top;

    assign zext = {{W{1'b0}}, a} << amt;
    assign sext = {{W{a[W-1]}}, a} << amt;
    assign res  = zext[W-1:0];
    assign lost = |zext[2*W-1:W];

    // the value fits when the upper W+1 bits are a pure sign extension
    genvar gi;
    generate
        for (gi = 0; gi <= W; gi++) begin : g_top
            assign top[gi] = sext[W-1+gi];
        end
    endgenerate

    assign sovf = ~((&top) | (~|top));
endmodule

// File: rtl/alu_mulw.sv
module alu_mulw #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] hi,
    output logic [W-1:0] lo
);
    logic [2*W-1:0] prod;

    assign prod = {{W{1'b0}}, a} * {{W{1'b0}}, b};
    assign hi   = prod[2*W-1:W];
    assign lo   = prod[W-1:0];
endmodule

// File: rtl/scalar_cc_alu.sv
module scalar_cc_alu
    import scalar_cc_alu_pkg::*;
#(
    parameter  int W  = 32,
    localparam int SW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [1:0]    op,
    input  logic          set_flags,
    input  logic [W-1:0]  opa,
    input  logic [W-1:0]  opb,
    input  logic [SW-1:0] shamt,
    output logic          out_valid,
    output logic [W-1:0]  res_lo,
    output logic [W-1:0]  res_hi,
    output logic          flag_c,
    output logic          flag_v,
    output logic          flag_n,
    output logic          flag_z
);
    alu_op_e    opc;
    seq_state_e state_q, state_d;

    logic [W-1:0] as_sum, sh_res, mu_hi, mu_lo;
    logic         as_c, as_v, sh_c, sh_v;

    logic [W-1:0] nxt_lo, nxt_hi;
    cc_rec_t      nxt_cc, cc_q;
    logic [W-1:0] lo_q, hi_q;

    assign opc = alu_op_e'(op);

    alu_addsub #(.W(W)) u_addsub (
        .sub   (opc == OP_SUB),
        .a     (opa),
        .b     (opb),
        .sum   (as_sum),
        .carry (as_c),
        .ovf   (as_v)
    );

    alu_shl #(.W(W), .SW(SW)) u_shl (
        .a    (opa),
        .amt  (shamt),
        .res  (sh_res),
        .lost (sh_c),
        .sovf (sh_v)
    );

    alu_mulw #(.W(W)) u_mul (
        .a  (opa),
        .b  (opb),
        .hi (mu_hi),
        .lo (mu_lo)
    );

    // operation select
    always_comb begin
        nxt_lo   = '0;
        nxt_hi   = '0;
        nxt_cc.c = 1'b0;
        nxt_cc.v = 1'b0;
        unique case (opc)
            OP_ADD, OP_SUB: begin
                nxt_lo   = as_sum;
                nxt_cc.c = as_c;
                nxt_cc.v = as_v;
            end
            OP_SHL: begin
                nxt_lo   = sh_res;
                nxt_cc.c = sh_c;
                nxt_cc.v = sh_v;
            end
            OP_MUL: begin
                nxt_lo   = mu_lo;
                nxt_hi   = mu_hi;
                nxt_cc.c = |mu_hi;
            end
            default: ;
        endcase
        nxt_cc.n = nxt_lo[W-1];
        nxt_cc.z = ~|nxt_lo;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: issue, stream, drain, rest
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_DONE : ST_IDLE;
            ST_DONE: state_d = in_valid ? ST_DONE : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // result and record registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
            cc_q <= '0;
        end else if (in_valid) begin
            lo_q <= nxt_lo;
            hi_q <= nxt_hi;
            if (set_flags) cc_q <= nxt_cc;
        end
    end

    // outputs
    always_comb begin
        out_valid = (state_q == ST_DONE);
        res_lo    = lo_q;
        res_hi    = hi_q;
        flag_c    = cc_q.c;
        flag_v    = cc_q.v;
        flag_n    = cc_q.n;
        flag_z    = cc_q.z;
    end
endmodule

// File: rtl/scalar_cc_alu_chk.sv
module scalar_cc_alu_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [1:0]   op,
    input logic         set_flags,
    input logic         out_valid,
    input logic [W-1:0] res_lo,
    input logic [W-1:0] res_hi,
    input logic         flag_c,
    input logic         flag_v,
    input logic         flag_n,
    input logic         flag_z
);
    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R1
    valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R9
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && set_flags) |=> $stable({flag_c, flag_v, flag_n, flag_z}));
    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable({res_hi, res_lo}));
    // R8
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && set_flags) |=> (flag_z == (res_lo == '0)));
    // R8
    neg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && set_flags) |=> (flag_n == res_lo[W-1]));
    // R6
    mul_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && set_flags && op == 2'b11) |=> (flag_c == (res_hi != '0)) && !flag_v);
    // R7
    hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op != 2'b11) |=> (res_hi == '0));
endmodule

bind scalar_cc_alu scalar_cc_alu_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op        (op),
    .set_flags (set_flags),
    .out_valid (out_valid),
    .res_lo    (res_lo),
    .res_hi    (res_hi),
    .flag_c    (flag_c),
    .flag_v    (flag_v),
    .flag_n    (flag_n),
    .flag_z    (flag_z)
);

// File: tb/sim_scalar_cc_alu.sv
`timescale 1ns/1ps
module sim_scalar_cc_alu;
    localparam int W  = 32;
    localparam int SW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [1:0]    op = 2'b00;
    logic          set_flags = 1'b0;
    logic [W-1:0]  opa = '0;
    logic [W-1:0]  opb = '0;
    logic [SW-1:0] shamt = '0;
    logic          out_valid;
    logic [W-1:0]  res_lo, res_hi;
    logic          flag_c, flag_v, flag_n, flag_z;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // expected state kept by the bench
    logic [W-1:0] e_lo = '0, e_hi = '0;
    logic [3:0]   e_cc = '0;  // {c,v,n,z}

    always #5 clk = ~clk;

    scalar_cc_alu #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .set_flags(set_flags), .opa(opa), .opb(opb), .shamt(shamt),
        .out_valid(out_valid), .res_lo(res_lo), .res_hi(res_hi),
        .flag_c(flag_c), .flag_v(flag_v), .flag_n(flag_n), .flag_z(flag_z)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic bit sfits(input longint v);
        return (v <= 64'sd2147483647) && (v >= -64'sd2147483648);
    endfunction

    // model: returns {hi, lo, c, v}
    function automatic logic [65:0] model(input logic [1:0] o, input logic [31:0] a,
                                          input logic [31:0] b, input logic [4:0] s);
        logic [63:0] w;
        longint sa, sb;
        logic c, v;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        w = '0; c = 0; v = 0;
        case (o)
            2'b00: begin w = {32'b0, a} + {32'b0, b}; c = w[32]; v = !sfits(sa + sb); w[63:32] = '0; end
            2'b01: begin w = {32'b0, a - b}; c = (a < b); v = !sfits(sa - sb); end
            2'b10: begin w = {32'b0, a} << s; c = |w[63:32]; v = !sfits(sa * (longint'(1) << s)); w[63:32] = '0; end
            default: begin w = {32'b0, a} * {32'b0, b}; c = |w[63:32]; v = 0; end
        endcase
        return {w, c, v};
    endfunction

    task automatic issue(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b,
                         input logic [4:0] s, input logic sf, input string req);
        logic [65:0] m;
        @(negedge clk);
        in_valid = 1; op = o; opa = a; opb = b; shamt = s; set_flags = sf;
        m = model(o, a, b, s);
        e_hi = m[65:34]; e_lo = m[33:2];
        if (sf) e_cc = {m[1], m[0], m[33], (m[33:2] == 0)};
        @(posedge clk); #1;
        chk({req, " R1 valid"}, {63'b0, out_valid}, 64'd1);
        chk({req, " lo"}, {32'b0, res_lo}, {32'b0, e_lo});
        chk({req, " R7 hi"}, {32'b0, res_hi}, {32'b0, e_hi});
        chk({req, " R9 flags"}, {60'b0, flag_c, flag_v, flag_n, flag_z}, {60'b0, e_cc});
    endtask

    task automatic idle(input string req);
        @(negedge clk);
        in_valid = 0; opa = $urandom; opb = $urandom; set_flags = 1;
        @(posedge clk); #1;
        chk({req, " R1 drain"}, {63'b0, out_valid}, 64'd0);
        chk({req, " R10 hold"}, {res_hi, res_lo}, {e_hi, e_lo});
        chk({req, " R9 hold"}, {60'b0, flag_c, flag_v, flag_n, flag_z}, {60'b0, e_cc});
    endtask

    function automatic logic [31:0] pick();
        case ($urandom % 6)
            0: return 32'h0000_0000;
            1: return 32'hFFFF_FFFF;
            2: return 32'h7FFF_FFFF;
            3: return 32'h8000_0000;
            default: return $urandom;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        // R11
        chk("R11 reset valid", {63'b0, out_valid}, 64'd0);
        chk("R11 reset results", {res_hi, res_lo}, 64'd0);
        chk("R11 reset flags", {60'b0, flag_c, flag_v, flag_n, flag_z}, 64'd0);
        @(negedge clk); rst_n = 1;

        issue(2'b00, 32'hFFFF_FFFF, 32'h1, 0, 1, "R2 carry wrap");
        issue(2'b00, 32'h7FFF_FFFF, 32'h1, 0, 1, "R2 signed ovf");
        issue(2'b01, 32'h0, 32'h1, 0, 1, "R3 borrow");
        issue(2'b01, 32'h8000_0000, 32'h1, 0, 1, "R3 signed ovf");
        issue(2'b01, 32'h5, 32'h5, 0, 1, "R3 zero R8");
        issue(2'b10, 32'h1234_5678, 0, 0, 1, "R4 shift zero");
        issue(2'b10, 32'h4000_0000, 0, 1, 1, "R5 sovf no carry");
        issue(2'b10, 32'hFFFF_FFFF, 0, 4, 1, "R5 carry no sovf");
        issue(2'b10, 32'h8000_0001, 0, 31, 1, "R4 max shift");
        issue(2'b11, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 1, "R6 max product");
        issue(2'b11, 32'h0001_0000, 32'h0000_FFFF, 0, 1, "R6 fits");
        issue(2'b00, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 0, 1, "R2 set record");
        issue(2'b01, 32'h0, 32'h0, 0, 0, "R9 no flag write");
        issue(2'b11, 32'hFFFF_FFFF, 32'h2, 0, 0, "R9 no flag write mul");
        idle("R10 gap");
        idle("R10 gap2");

        for (int i = 0; i < 400; i++) begin
            issue(2'($urandom % 4), pick(), pick(), 5'($urandom), 1'($urandom), "R2 R3 R4 R5 R6 R8 random");
            if ($urandom % 5 == 0) idle("R10 random gap");
        end

        @(negedge clk); in_valid = 0;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule